// File: doc/BRIEF.md
# SWD Debug Port Bring-Up Sequencer

This block takes a serial-wire debug port from an unknown state to a usable one after reset. It sits above a separate transaction engine, which shifts bits on the wire. The sequencer hands that engine one request at a time and evaluates each response. A pulse on `start` runs a fixed program with these steps:
- a line reset;
- an identification read, checked against the expected part-number field;
- a power-up request, followed by polling until the acknowledges are set;
- a debug-reset pulse, with its own poll for the acknowledge;
- a check that the default access port belongs to the memory class.

At the end the block raises `link_ready`, or it raises `link_err` together with an error code that names the stage that stopped it. Each of the two polls tries a bounded number of times. The limit is the parameter `POLL_TRIES`.

The engine interface works as follows:
- A request carries an operation code, a port select, two register-address bits and write data. `req_valid` stays asserted until the engine takes the request with `req_ready`.
- Only one request is outstanding at a time.
- The engine answers with a one-cycle `rsp_valid` that carries an acknowledge-OK flag and read data.

Access-port reads are posted on this kind of port: the read data arrives with the following transfer. For that reason the identity word is fetched from the debug port's read buffer and not from the access-port read response.

Top module: `swd_bringup_seq`

## Requirements
- R1: After synchronous reset, `busy`, `link_ready`, `link_err` and `req_valid` are 0 and `err_code` is 0.
- R2: The first request of a run is a line reset (`req_op`=0). It is followed by a debug-port read (`req_op`=1, `req_ap`=0) of address 0, which returns the identification word.
- R3: The identification word is accepted only if the word masked with 0x0FF00001 equals 0x0BA00001. Any other value ends the run with `err_code`=2.
- R4: The sequencer writes 0x50000000 to debug-port address 1 (control/status: system power request at bit 30, debug power request at bit 28). It then reads address 1 until bits 31 and 29 are both 1. If all `POLL_TRIES` reads fail, the run ends with `err_code`=3.
- R5: The sequencer writes 0x54000000 to address 1, adding the debug-reset request at bit 26. It then reads address 1 until bits 31, 29 and 27 are all 1. If all `POLL_TRIES` reads fail, the run ends with `err_code`=4.
- R6: After the reset acknowledge, the sequencer writes 0x50000000 to address 1, so a successful run makes exactly three control/status writes.
- R7: The sequencer writes 0x000000F0 to debug-port address 2 (bank select). It then issues an access-port read (`req_ap`=1) of address 3, whose data it ignores. Finally it reads debug-port address 3 (read buffer) and requires the low 4 bits of that word to equal 1. Any other value ends the run with `err_code`=5.
- R8: A response with `rsp_ok`=0 at any step ends the run at once with `err_code`=1.
- R9: `req_valid` and all request fields hold steady while `req_ready` is low.
- R10: `start` is ignored while `busy` is high. `start` from idle clears both status flags. A run always ends with exactly one of `link_ready` (with `err_code`=0) or `link_err` (with a nonzero code) set. No request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| req_valid | output | 1 | Request to the transaction engine is valid |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 2 | 0 line reset, 1 read, 2 write |
| req_ap | output | 1 | 1 selects the access port, 0 the debug port |
| req_addr | output | 2 | Register address bits [3:2] |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_ok | input | 1 | Acknowledge was OK and the data was good |
| rsp_rdata | input | 32 | Read data |
| busy | output | 1 | A run is in progress |
| link_ready | output | 1 | The last run succeeded |
| link_err | output | 1 | The last run failed |
| err_code | output | 3 | Failure stage, 0 when none |

## Verification
The hardest cases to reach are the retry boundaries of the two polls. One run must succeed on exactly the last allowed read, and a second run must time out after one more unacknowledged read. The bench's engine model counts control/status reads and raises the acknowledge bits only once a delay taken from the vector table has passed. Delays of `POLL_TRIES`-1 and `POLL_TRIES` land on each side of the limit. The model also returns a stale word for the posted access-port read and puts the real identity only into the read buffer. A design that checked the wrong response would therefore report a wrong access port.

// File: rtl/swd_bup_pkg.sv
package swd_bup_pkg;

    typedef enum logic [1:0] {
        OP_LINE_RESET = 2'd0,
        OP_READ       = 2'd1,
        OP_WRITE      = 2'd2
    } swd_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LRST,
        ST_IDCODE,
        ST_PWR_WR,
        ST_PWR_POLL,
        ST_RST_WR,
        ST_RST_POLL,
        ST_RST_CLR,
        ST_SEL_WR,
        ST_AP_RD,
        ST_BUF_RD
    } step_e;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_LINK   = 3'd1,
        ERR_PART   = 3'd2,
        ERR_PWR_TO = 3'd3,
        ERR_RST_TO = 3'd4,
        ERR_AP     = 3'd5
    } err_e;

    typedef struct packed {
        swd_op_e     op;
        logic        ap;
        logic [1:0]  addr;
        logic [31:0] wdata;
    } swd_req_t;

    // Control/status bit positions
    localparam int SYS_ACK_BIT = 31;
    localparam int SYS_REQ_BIT = 30;
    localparam int DBG_ACK_BIT = 29;
    localparam int DBG_REQ_BIT = 28;
    localparam int RST_ACK_BIT = 27;
    localparam int RST_REQ_BIT = 26;

    // Register slots (address bits [3:2])
    localparam logic [1:0] DP_IDCODE   = 2'd0;
    localparam logic [1:0] DP_CTRLSTAT = 2'd1;
    localparam logic [1:0] DP_SELECT   = 2'd2;
    localparam logic [1:0] DP_RDBUFF   = 2'd3;
    localparam logic [1:0] AP_IDR_SLOT = 2'd3;

    localparam logic [31:0] SEL_IDR_BANK = 32'h0000_00F0;

    function automatic logic [31:0] cs_word(input logic with_reset);
        logic [31:0] w;
        w              = '0;
        w[SYS_REQ_BIT] = 1'b1;
        w[DBG_REQ_BIT] = 1'b1;
        w[RST_REQ_BIT] = with_reset;
        return w;
    endfunction

    function automatic logic power_acked(input logic [31:0] d);
        return d[SYS_ACK_BIT] & d[DBG_ACK_BIT];
    endfunction

    function automatic logic reset_acked(input logic [31:0] d);
        return power_acked(d) & d[RST_ACK_BIT];
    endfunction

endpackage

// File: rtl/swd_bup_stepgen.sv
module swd_bup_stepgen
    import swd_bup_pkg::*;
(
    input  step_e    step,
    output swd_req_t req,
    output step_e    succ
);
    always_comb begin
        req  = '{op: OP_READ, ap: 1'b0, addr: 2'd0, wdata: 32'd0};
        succ = ST_IDLE;
        unique case (step)
            ST_LRST: begin
                req.op = OP_LINE_RESET;
                succ   = ST_IDCODE;
            end
            ST_IDCODE: begin
                req.addr = DP_IDCODE;
                succ     = ST_PWR_WR;
            end
            ST_PWR_WR: begin
                req.op    = OP_WRITE;
                req.addr  = DP_CTRLSTAT;
                req.wdata = cs_word(1'b0);
                succ      = ST_PWR_POLL;
            end
            ST_PWR_POLL: begin
                req.addr = DP_CTRLSTAT;
                succ     = ST_RST_WR;
            end
            ST_RST_WR: begin
                req.op    = OP_WRITE;
                req.addr  = DP_CTRLSTAT;
                req.wdata = cs_word(1'b1);
                succ      = ST_RST_POLL;
            end
            ST_RST_POLL: begin
                req.addr = DP_CTRLSTAT;
                succ     = ST_RST_CLR;
            end
            ST_RST_CLR: begin
                req.op    = OP_WRITE;
                req.addr  = DP_CTRLSTAT;
                req.wdata = cs_word(1'b0);
                succ      = ST_SEL_WR;
            end
            ST_SEL_WR: begin
                req.op    = OP_WRITE;
                req.addr  = DP_SELECT;
                req.wdata = SEL_IDR_BANK;
                succ      = ST_AP_RD;
            end
            ST_AP_RD: begin
                req.ap   = 1'b1;
                req.addr = AP_IDR_SLOT;
                succ     = ST_BUF_RD;
            end
            ST_BUF_RD: begin
                req.addr = DP_RDBUFF;
                succ     = ST_IDLE;
            end
            default: begin
                succ = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/swd_bup_check.sv
module swd_bup_check
    import swd_bup_pkg::*;
#(
    parameter logic [31:0] ID_MASK  = 32'h0FF0_0001,
    parameter logic [31:0] ID_MATCH = 32'h0BA0_0001,
    parameter logic [3:0]  AP_CLASS = 4'h1
) (
    input  step_e       step,
    input  logic [31:0] rdata,
    output logic        pass,
    output logic        is_poll,
    output err_e        fail_code
);
    always_comb begin
        pass      = 1'b1;
        is_poll   = 1'b0;
        fail_code = ERR_NONE;
        unique case (step)
            ST_IDCODE: begin
                pass      = (rdata & ID_MASK) == ID_MATCH;
                fail_code = ERR_PART;
            end
            ST_PWR_POLL: begin
                pass      = power_acked(rdata);
                is_poll   = 1'b1;
                fail_code = ERR_PWR_TO;
            end
            ST_RST_POLL: begin
                pass      = reset_acked(rdata);
                is_poll   = 1'b1;
                fail_code = ERR_RST_TO;
            end
            ST_BUF_RD: begin
                pass      = rdata[3:0] == AP_CLASS;
                fail_code = ERR_AP;
            end
            default: begin
                pass = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/swd_bup_pollcnt.sv
module swd_bup_pollcnt #(
    parameter int TRIES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CW = (TRIES < 2) ? 1 : $clog2(TRIES + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(TRIES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/swd_bringup_seq.sv
module swd_bringup_seq
    import swd_bup_pkg::*;
#(
    parameter int          POLL_TRIES = 4,
    parameter logic [31:0] ID_MASK    = 32'h0FF0_0001,
    parameter logic [31:0] ID_MATCH   = 32'h0BA0_0001,
    parameter logic [3:0]  AP_CLASS   = 4'h1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [1:0]  req_op,
    output logic        req_ap,
    output logic [1:0]  req_addr,
    output logic [31:0] req_wdata,
    input  logic        rsp_valid,
    input  logic        rsp_ok,
    input  logic [31:0] rsp_rdata,
    output logic        busy,
    output logic        link_ready,
    output logic        link_err,
    output logic [2:0]  err_code
);
    step_e    step_q;
    logic     waiting_q;
    logic     ready_q;
    logic     err_q;
    err_e     code_q;

    swd_req_t cur_req;
    step_e    succ;
    logic     chk_pass;
    logic     chk_poll;
    err_e     chk_code;
    logic     poll_last;
    logic     poll_clr;
    logic     poll_bump;

    swd_bup_stepgen u_stepgen (
        .step (step_q),
        .req  (cur_req),
        .succ (succ)
    );

    swd_bup_check #(
        .ID_MASK  (ID_MASK),
        .ID_MATCH (ID_MATCH),
        .AP_CLASS (AP_CLASS)
    ) u_check (
        .step      (step_q),
        .rdata     (rsp_rdata),
        .pass      (chk_pass),
        .is_poll   (chk_poll),
        .fail_code (chk_code)
    );

    logic active;
    logic take_rsp;
    assign active   = (step_q != ST_IDLE);
    assign take_rsp = active && waiting_q && rsp_valid;

    assign poll_bump = take_rsp && rsp_ok && !chk_pass && chk_poll && !poll_last;
    assign poll_clr  = (start && !active) || (take_rsp && rsp_ok && chk_pass);

    swd_bup_pollcnt #(
        .TRIES (POLL_TRIES)
    ) u_pollcnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (poll_clr),
        .bump (poll_bump),
        .last (poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= ST_IDLE;
            waiting_q <= 1'b0;
            ready_q   <= 1'b0;
            err_q     <= 1'b0;
            code_q    <= ERR_NONE;
        end else if (!active) begin
            if (start) begin
                step_q    <= ST_LRST;
                waiting_q <= 1'b0;
                ready_q   <= 1'b0;
                err_q     <= 1'b0;
                code_q    <= ERR_NONE;
            end
        end else if (!waiting_q) begin
            if (req_ready) begin
                waiting_q <= 1'b1;
            end
        end else if (rsp_valid) begin
            waiting_q <= 1'b0;
            if (!rsp_ok) begin
                step_q <= ST_IDLE;
                err_q  <= 1'b1;
                code_q <= ERR_LINK;
            end else if (chk_pass) begin
                step_q <= succ;
                if (step_q == ST_BUF_RD) begin
                    ready_q <= 1'b1;
                end
            end else if (chk_poll && !poll_last) begin
                step_q <= step_q;
            end else begin
                step_q <= ST_IDLE;
                err_q  <= 1'b1;
                code_q <= chk_code;
            end
        end
    end

    assign req_valid  = active && !waiting_q;
    assign req_op     = cur_req.op;
    assign req_ap     = cur_req.ap;
    assign req_addr   = cur_req.addr;
    assign req_wdata  = cur_req.wdata;
    assign busy       = active;
    assign link_ready = ready_q;
    assign link_err   = err_q;
    assign err_code   = code_q;
endmodule

// File: rtl/swd_bup_checker.sv
module swd_bup_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_op,
    input logic        req_ap,
    input logic [1:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic        busy,
    input logic        link_ready,
    input logic        link_err,
    input logic [2:0]  err_code
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable({req_op, req_ap, req_addr, req_wdata})); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid); // R10

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(link_ready && link_err)); // R10

    AST_RUN_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (link_ready != link_err)); // R10

    AST_ERR_CODED: assert property (@(posedge clk) disable iff (rst)
        link_err |-> err_code != 3'd0); // R8

    AST_READY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        link_ready |-> err_code == 3'd0); // R10

    AST_CS_WRITE_VAL: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd2 && !req_ap && req_addr == 2'd1
        |-> (req_wdata == 32'h5000_0000 || req_wdata == 32'h5400_0000)); // R4

    AST_SEL_WRITE_VAL: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd2 && req_addr == 2'd2 |-> req_wdata == 32'h0000_00F0); // R7
endmodule

bind swd_bringup_seq swd_bup_checker u_bup_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_ap     (req_ap),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .link_ready (link_ready),
    .link_err   (link_err),
    .err_code   (err_code)
);

// File: tb/tb_swd_bringup_seq.sv
module tb_swd_bringup_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [1:0]  req_op;
    logic        req_ap;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ok = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic        busy, link_ready, link_err;
    logic [2:0]  err_code;

    always #2 clk = ~clk;

    swd_bringup_seq dut (
        .clk(clk), .rst(rst), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_ap(req_ap), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .busy(busy), .link_ready(link_ready), .link_err(link_err), .err_code(err_code)
    );

    typedef struct packed {
        logic [31:0] idcode;
        logic [7:0]  pwr_delay;
        logic [7:0]  rst_delay;
        logic [31:0] idr;
        logic [7:0]  nak_idx;
        logic        exp_ready;
        logic [2:0]  exp_code;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{32'h2BA0_1477, 8'd0, 8'd0, 32'h2477_0011, 8'hFF, 1'b1, 3'd0},
        '{32'h2BA0_1477, 8'd3, 8'd3, 32'h2477_0011, 8'hFF, 1'b1, 3'd0},
        '{32'h2BA0_1477, 8'd4, 8'd0, 32'h2477_0011, 8'hFF, 1'b0, 3'd3},
        '{32'h2BA0_1477, 8'd1, 8'd4, 32'h2477_0011, 8'hFF, 1'b0, 3'd4},
        '{32'h2BB0_1477, 8'd0, 8'd0, 32'h2477_0011, 8'hFF, 1'b0, 3'd2},
        '{32'h2BA0_1476, 8'd0, 8'd0, 32'h2477_0011, 8'hFF, 1'b0, 3'd2},
        '{32'h2BA0_1477, 8'd0, 8'd0, 32'h2477_0012, 8'hFF, 1'b0, 3'd5},
        '{32'hFBA0_0001, 8'd2, 8'd1, 32'h0000_0001, 8'hFF, 1'b1, 3'd0},
        '{32'h2BA0_1477, 8'd0, 8'd0, 32'h2477_0011, 8'd4,  1'b0, 3'd1},
        '{32'h2BA0_1477, 8'd0, 8'd0, 32'h2477_0011, 8'd0,  1'b0, 3'd1}
    };

    int   n_checks = 0;
    int   n_fail   = 0;
    vec_t cfg;

    // Engine model state
    int          req_idx, stall, lrst_n, cs_wr_n, pwr_reads, rst_reads;
    logic        have_req, cs_wr_bad, sel_bad, first_bad, hold_bad;
    logic        pwr_on, rst_on, pwr_ok, rst_ok, ap_pend;
    logic [1:0]  r_op, r_addr;
    logic        r_ap;
    logic [31:0] r_wdata;
    logic [36:0] held;

    function automatic logic [31:0] cs_expect(input int k);
        return (k == 1) ? 32'h5400_0000 : 32'h5000_0000;
    endfunction

    initial begin
        cfg = VECS[0];
        req_idx = 0; stall = 0; lrst_n = 0; cs_wr_n = 0; pwr_reads = 0; rst_reads = 0;
        have_req = 0; cs_wr_bad = 0; sel_bad = 0; first_bad = 0; hold_bad = 0;
        pwr_on = 0; rst_on = 0; pwr_ok = 0; rst_ok = 0; ap_pend = 0;
        r_op = 0; r_addr = 0; r_ap = 0; r_wdata = 0; held = 0;
    end

    always @(negedge clk) begin
        if (start && !busy) begin
            req_idx = 0; stall = 0; lrst_n = 0; cs_wr_n = 0; pwr_reads = 0; rst_reads = 0;
            have_req = 0; cs_wr_bad = 0; sel_bad = 0; first_bad = 0; hold_bad = 0;
            pwr_on = 0; rst_on = 0; pwr_ok = 0; rst_ok = 0; ap_pend = 0;
        end
        req_ready = 1'b0;
        if (rsp_valid) begin
            rsp_valid = 1'b0;
        end else if (have_req) begin
            have_req  = 1'b0;
            rsp_ok    = (req_idx != int'(cfg.nak_idx));
            rsp_rdata = 32'h0;
            if (req_idx == 0 && r_op != 2'd0) first_bad = 1'b1;
            if (r_op == 2'd0) lrst_n++;
            else if (r_op == 2'd2 && !r_ap && r_addr == 2'd1) begin
                if (r_wdata != cs_expect(cs_wr_n)) cs_wr_bad = 1'b1;
                cs_wr_n++;
                pwr_on = r_wdata[30] & r_wdata[28];
                rst_on = r_wdata[26];
            end else if (r_op == 2'd2 && r_addr == 2'd2) begin
                if (r_wdata != 32'h0000_00F0) sel_bad = 1'b1;
            end else if (r_op == 2'd1 && r_ap) begin
                rsp_rdata = 32'h0000_0000;
            end else if (r_op == 2'd1 && r_addr == 2'd0) begin
                rsp_rdata = cfg.idcode;
            end else if (r_op == 2'd1 && r_addr == 2'd1) begin
                if (pwr_on && !pwr_ok) begin
                    if (pwr_reads >= int'(cfg.pwr_delay)) pwr_ok = 1'b1;
                    pwr_reads++;
                end
                if (rst_on && !rst_ok) begin
                    if (rst_reads >= int'(cfg.rst_delay)) rst_ok = 1'b1;
                    rst_reads++;
                end
                rsp_rdata[31] = pwr_ok; rsp_rdata[29] = pwr_ok;
                rsp_rdata[30] = pwr_on; rsp_rdata[28] = pwr_on;
                rsp_rdata[27] = rst_ok && rst_on; rsp_rdata[26] = rst_on;
            end else if (r_op == 2'd1 && r_addr == 2'd3) begin
                rsp_rdata = ap_pend ? cfg.idr : 32'h0;
            end
            ap_pend   = (r_op == 2'd1) && r_ap;
            rsp_valid = 1'b1;
            req_idx++;
        end else if (req_valid && !(start && !busy)) begin
            if (stall == 0) held = {req_op, req_ap, req_addr, req_wdata};
            else if (held != {req_op, req_ap, req_addr, req_wdata}) hold_bad = 1'b1;
            if (stall < (req_idx % 3)) begin
                stall++;
            end else begin
                r_op = req_op; r_ap = req_ap; r_addr = req_addr; r_wdata = req_wdata;
                req_ready = 1'b1;
                have_req  = 1'b1;
                stall     = 0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string code_tag(input logic [2:0] c);
        case (c)
            3'd1: return "R8";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic run_case(input vec_t v, input bit poke);
        int n;
        cfg = v;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && !link_ready && !link_err, "R10", "status cleared at start",
            {busy, link_ready, link_err}, 3'b100);
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
            start = (poke && n == 6);
        end
        start = 1'b0;
        chk(!busy, "R10", "run finished", busy, 0);
        chk(link_ready == v.exp_ready && link_err == !v.exp_ready, code_tag(v.exp_code),
            "verdict", {link_ready, link_err}, {v.exp_ready, !v.exp_ready});
        chk(err_code == v.exp_code, code_tag(v.exp_code), "err_code", err_code, v.exp_code);
        chk(!hold_bad, "R9", "request held under backpressure", hold_bad, 0);
        chk(!first_bad, "R2", "first request is line reset", first_bad, 0);
        if (v.exp_ready) begin
            chk(lrst_n == 1, "R2", "line reset count", lrst_n, 1);
            chk(cs_wr_n == 3 && !cs_wr_bad, "R6", "control writes", cs_wr_n, 3);
            chk(!sel_bad, "R7", "bank select value", sel_bad, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !link_ready && !link_err && !req_valid && err_code == 0, "R1",
            "reset outputs", {busy, link_ready, link_err, req_valid, err_code}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !req_valid, "R1", "idle after reset", {busy, req_valid}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_case(VECS[i], 1'b0);
        end

        // R10: start pulse mid-run is ignored (one line reset, normal success)
        run_case(VECS[1], 1'b1);
        // R10: recovery after a failure clears the error
        run_case(VECS[2], 1'b0);
        run_case(VECS[0], 1'b0);
        chk(err_code == 0 && !link_err, "R10", "error cleared by new run", err_code, 0);

        // R1: reset mid-run returns to idle
        cfg = VECS[1];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !req_valid && !link_ready && !link_err, "R1", "reset during run",
            {busy, req_valid, link_ready, link_err}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule